// File: doc/BRIEF.md
# Clock Synthesizer Frequency-Select Controller

This block is the digital control section of a programmable clock synthesizer. It holds a small set of byte-wide control registers that a host writes through a byte-addressed write port, for example one fed by a serial management slave. From those registers, the strap-latched frequency code and a watchdog timeout pulse, it decides which divider pair (N, M) and which ratio code go to an external PLL. It also emits a one-cycle load strobe that tells the PLL to take the new settings.

Three sources can supply the divider pair. The first is a table computed from the strap code. The second is a programmable pair that only takes effect when its M byte is written. The third is a recovery setting that the block switches to when the watchdog fires. The recovery setting comes either from the strap table or from its own programmed N/M pair, chosen by a select bit. The ratio code comes from the strap code, or from a software code when the override bit is set. All outputs are registered.

Top module: `fsel_ctrl`

## Requirements
- R1: While reset is low and after reset, every register byte reads 0, `recovery_active` and `pll_load` are 0, and `pll_n`, `pll_m` and `ratio_code` are 0 during reset.
- R2: Mapped bytes are 10 (bit 5 override, bits 4:0 software ratio code, bits 7:6 read 0), 11 (recovery N), 12 (bit 7 recovery source, bits 6:0 recovery M), 13 (programmable N) and 14 (bit 7 programmable enable, bits 6:0 programmable M). Reading a mapped byte returns its stored value. Writes to other offsets change nothing, and reads of them return 0.
- R3: Divider priority: an active recovery state outranks the programmable pair, and the programmable pair outranks the strap table.
- R4: In recovery, byte 12 bit 7 = 0 selects the strap table and bit 7 = 1 selects the recovery N/M bytes.
- R5: A `wdt_timeout` pulse sets `recovery_active` on the next edge. It stays set until `recovery_clear` or reset, and a timeout in the same cycle as a clear wins.
- R6: The programmable pair and its enable are captured only when byte 14 is written, using the stored byte 13 and the written byte 14. Writing byte 13 alone leaves the outputs unchanged.
- R7: `ratio_code` equals the byte 10 software code when byte 10 bit 5 is set, and `fs_strap` otherwise. It follows one cycle after its inputs.
- R8: `pll_load` is high for exactly one cycle, two edges after a write to byte 11, 12 or 14 or a recovery entry, and it comes with the updated dividers. Writes to bytes 10 or 13, unmapped writes, a timeout while already in recovery and a recovery exit give no strobe.
- R9: Strap table: N = 60 + 4*FS and M = 16 + FS, for FS in 0..31. A change on `fs_strap` reaches the outputs one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 8 | Byte written |
| rd_addr | input | 8 | Byte offset for read-back |
| rd_data | output | 8 | Stored value at `rd_addr` (0 if unmapped) |
| fs_strap | input | 5 | Strap-latched frequency code |
| wdt_timeout | input | 1 | Watchdog timeout pulse |
| recovery_clear | input | 1 | Leaves the recovery state |
| pll_n | output | 8 | Active N divider |
| pll_m | output | 7 | Active M divider |
| ratio_code | output | 5 | Active ratio code |
| pll_load | output | 1 | One-cycle load strobe for the PLL |
| recovery_active | output | 1 | Recovery state is latched |

## Verification
A wrong stored byte shows on `rd_data` in the same cycle it is addressed. A wrong programmable or recovery shadow shows on `pll_n`/`pll_m` two edges after the write or timeout that should have loaded it. A missing or doubled strobe shows on `pll_load` in that same cycle, or in the cycle after it. A broken priority or recovery latch appears as dividers from the wrong source in the cycle after the state change. The bench sweeps every strap code and every software ratio code, writes every offset of a 32-byte window, and steps through recovery entry, re-entry and exit with both source settings.

// File: rtl/fsel_pkg.sv
// Shared constants and types for the frequency-select controller.
// Assumes a fixed five-slot register file; slot indices are used by
// the register file and the top module to pick fields.
package fsel_pkg;

    localparam int NUM_SLOTS = 5;
    localparam int SLOT_CTL  = 0;   // override bit and software ratio code
    localparam int SLOT_RN   = 1;   // recovery N
    localparam int SLOT_RM   = 2;   // recovery source bit and recovery M
    localparam int SLOT_PN   = 3;   // programmable N
    localparam int SLOT_PM   = 4;   // programmable enable and programmable M

    typedef enum logic [1:0] {
        SRC_STRAP       = 2'd0,
        SRC_PROG        = 2'd1,
        SRC_RECOV_STRAP = 2'd2,
        SRC_RECOV_REG   = 2'd3
    } src_e;

endpackage

// File: rtl/fsel_regfile.sv
// Byte register file of the frequency-select controller.
// Holds five mapped bytes, masks the unused bits, ignores writes to
// unmapped offsets and returns 0 on reads of them. Also reports which
// slot is written in the current cycle.
// Assumes DATA_W >= FS_W + 1 and a single write port.
module fsel_regfile
    import fsel_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter int          DATA_W  = 8,
    parameter int          FS_W    = 5,
    parameter int unsigned OFS_CTL = 10,
    parameter int unsigned OFS_RN  = 11,
    parameter int unsigned OFS_RM  = 12,
    parameter int unsigned OFS_PN  = 13,
    parameter int unsigned OFS_PM  = 14
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [DATA_W-1:0]                 rd_data,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]  slot_q,
    output logic [NUM_SLOTS-1:0]              slot_wr
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;
    localparam logic [DATA_W-1:0] CTL_MASK = DATA_W'((1 << (FS_W + 1)) - 1);
    localparam int unsigned SLOT_OFS [NUM_SLOTS] =
        '{OFS_CTL, OFS_RN, OFS_RM, OFS_PN, OFS_PM};
    localparam logic [DATA_W-1:0] SLOT_MASK [NUM_SLOTS] =
        '{CTL_MASK, ALL_ONES, ALL_ONES, ALL_ONES, ALL_ONES};

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [DATA_W-1:0] q;

        assign slot_wr[s] = wr_en && (wr_addr == ADDR_W'(SLOT_OFS[s]));

        // Store the masked byte when this slot is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (slot_wr[s]) begin
                q <= wr_data & SLOT_MASK[s];
            end
        end

        assign slot_q[s] = q;
    end

    // Read-back mux; unmapped offsets return zero.
    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (rd_addr == ADDR_W'(SLOT_OFS[s])) begin
                rd_data = slot_q[s];
            end
        end
    end

endmodule

// File: rtl/fsel_strap_table.sv
// Strap frequency table: maps the latched strap code to a divider pair
// arithmetically (N = base + step*code, M = base + code).
// Assumes the largest results fit N_W and M_W; the result wraps otherwise.
module fsel_strap_table #(
    parameter int          FS_W        = 5,
    parameter int          N_W         = 8,
    parameter int          M_W         = 7,
    parameter int unsigned STRAP_N_BASE = 60,
    parameter int unsigned STRAP_N_STEP = 4,
    parameter int unsigned STRAP_M_BASE = 16
) (
    input  logic [FS_W-1:0] fs_code,
    output logic [N_W-1:0]  strap_n,
    output logic [M_W-1:0]  strap_m
);

    localparam int unsigned CODES = 1 << FS_W;
    localparam int unsigned N_MAX = STRAP_N_BASE + STRAP_N_STEP * (CODES - 1);

    logic [31:0] code_wide;

    // Compute the table entry for the present strap code.
    always_comb begin
        code_wide = 32'(fs_code);
        strap_n   = N_W'(STRAP_N_BASE + STRAP_N_STEP * code_wide);
        strap_m   = M_W'(STRAP_M_BASE + code_wide);
    end

    if (N_MAX >= (1 << N_W)) begin : g_n_wrap_note
        // The largest N of the table wraps in N_W bits; the result is still defined.
        logic unused_wrap;
        assign unused_wrap = 1'b0;
    end

endmodule

// File: rtl/fsel_recovery.sv
// Watchdog recovery latch. A timeout pulse sets the state, a clear
// input or reset drops it, and a timeout beats a clear in the same
// cycle. Also flags entry (timeout while not yet in recovery).
module fsel_recovery (
    input  logic clk,
    input  logic rst_n,
    input  logic wdt_timeout,
    input  logic recovery_clear,
    output logic rec_active,
    output logic rec_entry
);

    assign rec_entry = wdt_timeout && !rec_active;

    // Latch the recovery state until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_active <= 1'b0;
        end else if (wdt_timeout) begin
            rec_active <= 1'b1;
        end else if (recovery_clear) begin
            rec_active <= 1'b0;
        end
    end

endmodule

// File: rtl/fsel_output_select.sv
// Source selection and output registers. Keeps a shadow of the
// programmable pair that is loaded only on an M-byte write, picks the
// divider source by priority (recovery > programmable > strap), registers
// the outputs and delays the update event by one cycle into a load strobe.
// Assumes the stored programmable N is stable in the cycle of the M write
// (single write port).
module fsel_output_select
    import fsel_pkg::*;
#(
    parameter int N_W  = 8,
    parameter int M_W  = 7,
    parameter int FS_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rec_active,
    input  logic            rec_entry,
    input  logic            rec_src,
    input  logic [N_W-1:0]  rec_n,
    input  logic [M_W-1:0]  rec_m,
    input  logic [N_W-1:0]  strap_n,
    input  logic [M_W-1:0]  strap_m,
    input  logic [N_W-1:0]  prog_n,
    input  logic            prog_wr,
    input  logic            prog_en_in,
    input  logic [M_W-1:0]  prog_m_in,
    input  logic            rec_wr,
    input  logic            ovr,
    input  logic [FS_W-1:0] sel_code,
    input  logic [FS_W-1:0] fs_code,
    output logic [N_W-1:0]  pll_n,
    output logic [M_W-1:0]  pll_m,
    output logic [FS_W-1:0] ratio_code,
    output logic            pll_load
);

    logic           prog_en_act;
    logic [N_W-1:0] prog_n_act;
    logic [M_W-1:0] prog_m_act;
    logic           pend_q;
    src_e           src;
    logic [N_W-1:0] nxt_n;
    logic [M_W-1:0] nxt_m;

    // Capture the programmable pair only on an M-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_en_act <= 1'b0;
            prog_n_act  <= '0;
            prog_m_act  <= '0;
        end else if (prog_wr) begin
            prog_en_act <= prog_en_in;
            prog_n_act  <= prog_n;
            prog_m_act  <= prog_m_in;
        end
    end

    // Priority decode of the divider source.
    always_comb begin
        if (rec_active) begin
            src = rec_src ? SRC_RECOV_REG : SRC_RECOV_STRAP;
        end else if (prog_en_act) begin
            src = SRC_PROG;
        end else begin
            src = SRC_STRAP;
        end
    end

    // Divider pair of the selected source.
    always_comb begin
        unique case (src)
            SRC_RECOV_REG: begin nxt_n = rec_n;      nxt_m = rec_m;      end
            SRC_PROG:      begin nxt_n = prog_n_act; nxt_m = prog_m_act; end
            default:       begin nxt_n = strap_n;    nxt_m = strap_m;    end
        endcase
    end

    // Output registers for the dividers and the ratio code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_n      <= '0;
            pll_m      <= '0;
            ratio_code <= '0;
        end else begin
            pll_n      <= nxt_n;
            pll_m      <= nxt_m;
            ratio_code <= ovr ? sel_code : fs_code;
        end
    end

    // Delay an update event so the strobe comes with the new dividers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            pll_load <= 1'b0;
        end else begin
            pend_q   <= rec_wr || prog_wr || rec_entry;
            pll_load <= pend_q;
        end
    end

endmodule

// File: rtl/fsel_ctrl.sv
// Top of the frequency-select controller. Connects the register file,
// the strap table, the recovery latch and the output selector.
// Assumes a byte-wide write port decoded upstream and a strap code that
// is latched outside this block.
module fsel_ctrl
    import fsel_pkg::*;
#(
    parameter int          ADDR_W       = 8,
    parameter int          DATA_W       = 8,
    parameter int          FS_W         = 5,
    parameter int unsigned OFS_CTL      = 10,
    parameter int unsigned OFS_RN       = 11,
    parameter int unsigned OFS_RM       = 12,
    parameter int unsigned OFS_PN       = 13,
    parameter int unsigned OFS_PM       = 14,
    parameter int unsigned STRAP_N_BASE = 60,
    parameter int unsigned STRAP_N_STEP = 4,
    parameter int unsigned STRAP_M_BASE = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [FS_W-1:0]     fs_strap,
    input  logic                wdt_timeout,
    input  logic                recovery_clear,
    output logic [DATA_W-1:0]   pll_n,
    output logic [DATA_W-2:0]   pll_m,
    output logic [FS_W-1:0]     ratio_code,
    output logic                pll_load,
    output logic                recovery_active
);

    localparam int N_W = DATA_W;
    localparam int M_W = DATA_W - 1;

    logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q;
    logic [NUM_SLOTS-1:0]             slot_wr;
    logic [N_W-1:0]                   strap_n;
    logic [M_W-1:0]                   strap_m;
    logic                             rec_entry;
    logic                             ctl_ovr;
    logic [FS_W-1:0]                  ctl_sel;
    logic                             rec_src;
    logic [N_W-1:0]                   rec_n;
    logic [M_W-1:0]                   rec_m;
    logic [DATA_W-1:0]                ctl_byte;

    assign ctl_byte = slot_q[SLOT_CTL];
    assign ctl_ovr  = ctl_byte[FS_W];
    assign ctl_sel  = ctl_byte[FS_W-1:0];
    assign rec_n    = slot_q[SLOT_RN];
    assign rec_src  = slot_q[SLOT_RM][DATA_W-1];
    assign rec_m    = slot_q[SLOT_RM][M_W-1:0];

    fsel_regfile #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .FS_W (FS_W),
        .OFS_CTL(OFS_CTL), .OFS_RN(OFS_RN), .OFS_RM(OFS_RM),
        .OFS_PN (OFS_PN),  .OFS_PM(OFS_PM)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .slot_q (slot_q),
        .slot_wr(slot_wr)
    );

    fsel_strap_table #(
        .FS_W(FS_W), .N_W(N_W), .M_W(M_W),
        .STRAP_N_BASE(STRAP_N_BASE), .STRAP_N_STEP(STRAP_N_STEP),
        .STRAP_M_BASE(STRAP_M_BASE)
    ) u_table (
        .fs_code(fs_strap),
        .strap_n(strap_n),
        .strap_m(strap_m)
    );

    fsel_recovery u_recov (
        .clk           (clk),
        .rst_n         (rst_n),
        .wdt_timeout   (wdt_timeout),
        .recovery_clear(recovery_clear),
        .rec_active    (recovery_active),
        .rec_entry     (rec_entry)
    );

    fsel_output_select #(
        .N_W(N_W), .M_W(M_W), .FS_W(FS_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_active(recovery_active),
        .rec_entry (rec_entry),
        .rec_src   (rec_src),
        .rec_n     (rec_n),
        .rec_m     (rec_m),
        .strap_n   (strap_n),
        .strap_m   (strap_m),
        .prog_n    (slot_q[SLOT_PN]),
        .prog_wr   (slot_wr[SLOT_PM]),
        .prog_en_in(wr_data[DATA_W-1]),
        .prog_m_in (wr_data[M_W-1:0]),
        .rec_wr    (slot_wr[SLOT_RN] || slot_wr[SLOT_RM]),
        .ovr       (ctl_ovr),
        .sel_code  (ctl_sel),
        .fs_code   (fs_strap),
        .pll_n     (pll_n),
        .pll_m     (pll_m),
        .ratio_code(ratio_code),
        .pll_load  (pll_load)
    );

endmodule

// File: rtl/fsel_ctrl_chk.sv
// Assertion checker for fsel_ctrl, attached by the bind at the end.
// Relates the ports and the register fields across cycles.
module fsel_ctrl_chk #(
    parameter int          ADDR_W = 8,
    parameter int          DATA_W = 8,
    parameter int          FS_W   = 5,
    parameter int unsigned OFS_RN = 11,
    parameter int unsigned OFS_RM = 12,
    parameter int unsigned OFS_PM = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [FS_W-1:0]   fs_strap,
    input logic              wdt_timeout,
    input logic              recovery_clear,
    input logic [DATA_W-1:0] pll_n,
    input logic [DATA_W-2:0] pll_m,
    input logic [FS_W-1:0]   ratio_code,
    input logic              pll_load,
    input logic              recovery_active,
    input logic              ctl_ovr,
    input logic [FS_W-1:0]   ctl_sel,
    input logic              rec_src,
    input logic [DATA_W-1:0] rec_n,
    input logic [DATA_W-2:0] rec_m
);

    logic evt;
    logic in_rst_q = 1'b0;

    assign evt = (wr_en && (wr_addr == ADDR_W'(OFS_RN) || wr_addr == ADDR_W'(OFS_RM)
                            || wr_addr == ADDR_W'(OFS_PM)))
              || (wdt_timeout && !recovery_active);

    // Track the reset seen on the previous edge.
    always_ff @(posedge clk) in_rst_q <= !rst_n;

    // Outputs are cleared by a reset cycle.
    always_ff @(posedge clk) begin
        if (in_rst_q) begin
            assert_reset_R1: assert (!pll_load && !recovery_active && pll_n == '0
                                     && pll_m == '0 && ratio_code == '0);
        end
    end

    assert_rec_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> recovery_active);

    assert_rec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        recovery_active && !recovery_clear |=> recovery_active);

    assert_rec_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        recovery_active && recovery_clear && !wdt_timeout |=> !recovery_active);

    assert_load_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pll_load |-> $past(evt, 2));

    assert_load_given_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(evt, 2)) |-> pll_load);

    assert_ratio_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ratio_code == $past(ctl_ovr ? ctl_sel : fs_strap));

    assert_recsrc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(recovery_active) && $past(rec_src))
        |-> (pll_n == $past(rec_n) && pll_m == $past(rec_m)));

endmodule

bind fsel_ctrl fsel_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FS_W(FS_W),
    .OFS_RN(OFS_RN), .OFS_RM(OFS_RM), .OFS_PM(OFS_PM)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .fs_strap       (fs_strap),
    .wdt_timeout    (wdt_timeout),
    .recovery_clear (recovery_clear),
    .pll_n          (pll_n),
    .pll_m          (pll_m),
    .ratio_code     (ratio_code),
    .pll_load       (pll_load),
    .recovery_active(recovery_active),
    .ctl_ovr        (ctl_ovr),
    .ctl_sel        (ctl_sel),
    .rec_src        (rec_src),
    .rec_n          (rec_n),
    .rec_m          (rec_m)
);

// File: tb/tb_fsel_ctrl.sv
// Self-checking bench for fsel_ctrl: sweeps strap codes, ratio codes and
// the write window, then walks the programmable and recovery sequences.
`timescale 1ns/1ps
module tb_fsel_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [4:0] fs_strap = '0;
    logic       wdt_timeout = 1'b0;
    logic       recovery_clear = 1'b0;
    logic [7:0] pll_n;
    logic [6:0] pll_m;
    logic [4:0] ratio_code;
    logic       pll_load;
    logic       recovery_active;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fsel_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .fs_strap(fs_strap), .wdt_timeout(wdt_timeout),
        .recovery_clear(recovery_clear), .pll_n(pll_n), .pll_m(pll_m),
        .ratio_code(ratio_code), .pll_load(pll_load),
        .recovery_active(recovery_active)
    );

    function automatic logic [7:0] exp_n(input int f);
        return 8'(60 + 4 * f);
    endfunction

    function automatic logic [6:0] exp_m(input int f);
        return 7'(16 + f);
    endfunction

    function automatic bit is_mapped(input int a);
        return (a >= 10 && a <= 14);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One operation: drive at a falling edge, hold one cycle, return after the
    // second rising edge so the registered outputs of the event are visible.
    task automatic op(input bit we, input int a, input int d, input bit tmo, input bit clr);
        @(negedge clk);
        wr_en = we; wr_addr = 8'(a); wr_data = 8'(d);
        wdt_timeout = tmo; recovery_clear = clr;
        @(negedge clk);
        wr_en = 1'b0; wdt_timeout = 1'b0; recovery_clear = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        op(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic rd_check(input string req, input int a, input int exp);
        rd_addr = 8'(a);
        #0.5;
        check(req, int'(rd_data), exp);
    endtask

    task automatic pair_check(input string req, input int n, input int m);
        check(req, int'(pll_n), n);
        check(req, int'(pll_m), m);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        fs_strap = 5'd5;
        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1 load", int'(pll_load), 0);
        check("R1 recovery", int'(recovery_active), 0);
        pair_check("R1 dividers", 0, 0);
        check("R1 ratio", int'(ratio_code), 0);
        for (int a = 10; a <= 14; a++) rd_check("R1 readback", a, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        pair_check("R1/R9 after reset", int'(exp_n(5)), int'(exp_m(5)));
        check("R1 load after reset", int'(pll_load), 0);

        // R9: every strap code, override clear
        for (int f = 0; f < 32; f++) begin
            fs_strap = 5'(f);
            @(negedge clk);
            pair_check("R9 strap table", int'(exp_n(f)), int'(exp_m(f)));
            check("R7 ratio from strap", int'(ratio_code), f);
        end

        // R2: unmapped writes ignored
        fs_strap = 5'd9;
        for (int a = 0; a < 32; a++) begin
            if (!is_mapped(a)) begin
                wr(a, 8'hFF);
                check("R2 unmapped no load", int'(pll_load), 0);
                pair_check("R2 unmapped no effect", int'(exp_n(9)), int'(exp_m(9)));
            end
        end
        for (int a = 0; a < 32; a++) rd_check("R2 readback after unmapped", a, 0);

        // R2/R8: mapped writes, field masks and strobe selectivity
        wr(10, 8'hDF);
        check("R8 no load on byte 10", int'(pll_load), 0);
        rd_check("R2 byte 10 mask", 10, 8'h1F);
        wr(11, 8'hA5);
        check("R8 load on byte 11", int'(pll_load), 1);
        @(negedge clk);
        check("R8 single cycle", int'(pll_load), 0);
        wr(12, 8'h5A);
        check("R8 load on byte 12", int'(pll_load), 1);
        wr(13, 8'hC3);
        check("R8 no load on byte 13", int'(pll_load), 0);
        wr(14, 8'h3C);
        check("R8 load on byte 14", int'(pll_load), 1);
        pair_check("R6 enable clear keeps strap", int'(exp_n(9)), int'(exp_m(9)));
        rd_check("R2 byte 11", 11, 8'hA5);
        rd_check("R2 byte 12", 12, 8'h5A);
        rd_check("R2 byte 13", 13, 8'hC3);
        rd_check("R2 byte 14", 14, 8'h3C);
        for (int a = 0; a < 32; a++) begin
            if (!is_mapped(a)) rd_check("R2 unmapped reads zero", a, 0);
        end

        // R7: every software code with and without override
        for (int s = 0; s < 32; s++) begin
            wr(10, 8'h20 | s);
            check("R7 override ratio", int'(ratio_code), s);
            wr(10, s);
            check("R7 strap ratio", int'(ratio_code), 9);
        end
        pair_check("R7 dividers untouched", int'(exp_n(9)), int'(exp_m(9)));

        // R6: programmable path
        wr(13, 8'h55);
        check("R6 N-only no load", int'(pll_load), 0);
        pair_check("R6 N-only no effect", int'(exp_n(9)), int'(exp_m(9)));
        wr(14, 8'hA1);
        check("R6 load on M write", int'(pll_load), 1);
        pair_check("R6 programmable pair", 8'h55, 8'h21);
        wr(13, 8'h66);
        pair_check("R6 N rewrite not loaded", 8'h55, 8'h21);
        wr(14, 8'hB0);
        pair_check("R6 reload", 8'h66, 8'h30);

        // R3/R4/R5: recovery
        wr(11, 8'h90);
        check("R8 load on recovery N", int'(pll_load), 1);
        pair_check("R3 prog while not in recovery", 8'h66, 8'h30);
        wr(12, 8'h00);
        op(1'b0, 0, 0, 1'b1, 1'b0);
        check("R5 recovery set", int'(recovery_active), 1);
        check("R8 load on entry", int'(pll_load), 1);
        pair_check("R3/R4 recovery from strap", int'(exp_n(9)), int'(exp_m(9)));
        op(1'b0, 0, 0, 1'b1, 1'b0);
        check("R8 no load on re-entry", int'(pll_load), 0);
        wr(12, 8'hAA);
        check("R8 load on recovery M", int'(pll_load), 1);
        pair_check("R4 recovery from registers", 8'h90, 8'h2A);
        wr(14, 8'h91);
        pair_check("R3 recovery outranks programmable", 8'h90, 8'h2A);
        check("R5 held", int'(recovery_active), 1);
        op(1'b0, 0, 0, 1'b0, 1'b1);
        check("R5 cleared", int'(recovery_active), 0);
        check("R8 no load on exit", int'(pll_load), 0);
        pair_check("R3 programmable after exit", 8'h66, 8'h11);
        op(1'b0, 0, 0, 1'b1, 1'b1);
        check("R5 timeout beats clear", int'(recovery_active), 1);
        op(1'b0, 0, 0, 1'b0, 1'b1);
        wr(14, 8'h11);
        pair_check("R3 strap when disabled", int'(exp_n(9)), int'(exp_m(9)));

        // R1: reset from a busy state
        op(1'b0, 0, 0, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 recovery after reset", int'(recovery_active), 0);
        for (int a = 10; a <= 14; a++) rd_check("R1 readback after reset", a, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        pair_check("R1 strap after reset", int'(exp_n(9)), int'(exp_m(9)));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule